// File: doc/BRIEF.md
# Component-Aware Read-After-Write Scoreboard

This block guards the issue stage of an in-order vector shader pipeline whose operations complete after different numbers of cycles. Every accepted instruction that writes a register claims a slot. The slot holds the destination address, the set of vector lanes written (x, y, z, w), and a down-counter loaded from the instruction's latency class. When the counter runs out, the result counts as written back and the slot is released.

Each cycle the block compares up to three source operands of the instruction waiting at issue against every live slot, lane by lane. When a source needs a lane that a slot has not yet written back, the block raises `stall`. Issue then sends a bubble instead of the instruction and presents the same instruction again in the next cycle. The block also raises `stall` when a writing instruction finds no free slot. A later write to the same register takes over from an older one on the lanes it covers, so only the youngest pending write to a lane can hold a reader back.

Top module: `hazardScoreboard`

## Requirements
- R1: After synchronous active-high reset no slot is live, so no source read stalls until a new write is accepted.
- R2: `stall` is high when `issueValid` is high and an enabled source address equals the destination of a live slot whose write mask shares a lane with that source's read mask.
- R3: A source whose address matches a live slot but whose read mask shares no lane with that slot's write mask does not stall.
- R4: `latClass` encodes 0 = multiply (1 cycle), 1 = two-input add (2), 2 = dot product (4), 3 = special function (7). A reader issued right after a writer of latency L stalls for exactly L-1 cycles. In the cycle the counter expires, the read is treated as already written back.
- R5: No slot is claimed by a stalled instruction, by a cycle with `issueValid` low, or by an instruction with `wrMask` = 0.
- R6: When a new write to an address is accepted, older slots for that address lose the lanes the new write covers. On each lane only the youngest pending write can cause a stall.
- R7: An instruction with a nonzero `wrMask` stalls while all slots are live, even if it has no data hazard. An instruction that writes nothing never stalls for lack of a slot.
- R8: All three source slots are checked. A source with read mask 0 is unused and never matches. Source k occupies bits [k*ADDR_W +: ADDR_W] of `srcAddr` and bits [k*4 +: 4] of `srcMask`, and lane bit 0 is x.
- R9: A live slot's counter falls by exactly one each cycle until it is reused.
- R10: `stall` is low whenever `issueValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | An instruction is presented for issue |
| srcAddr | input | NUM_SRC*ADDR_W | Packed source register addresses |
| srcMask | input | NUM_SRC*4 | Packed per-source lane read masks |
| dstAddr | input | ADDR_W | Destination register address |
| wrMask | input | 4 | Destination lane write mask, 0 = no write |
| latClass | input | 2 | Latency class of the instruction |
| stall | output | 1 | Hold issue and insert a bubble this cycle |

## Verification
A counter that is loaded wrongly or decrements wrongly shows up as a stall run that is too long or too short, on the first dependent read after the faulty write. A slot that is not superseded, or that is claimed by a bubble, causes a stall where none is due within the producer's latency window of at most seven cycles. Lane or source-slot compare errors show up in the same cycle as a wrong `stall` value. A slot leak shows up only when the slots are full, so a reduced-depth instance is driven to the full condition as well.

// File: rtl/hazardSbPkg.sv
package hazardSbPkg;

  localparam int SB_IDX_W = 5;  // supports up to 32 slots

  typedef enum logic [1:0] {
    LAT_MUL = 2'd0,
    LAT_ADD = 2'd1,
    LAT_DOT = 2'd2,
    LAT_SFU = 2'd3
  } latClass_e;

  // strobes from control to the slot file
  typedef struct packed {
    logic                alloc;
    logic [SB_IDX_W-1:0] idx;
  } sbCtrl_t;

  function automatic logic [3:0] latCycles(input logic [1:0] cls);
    case (cls)
      LAT_MUL: latCycles = 4'd1;
      LAT_ADD: latCycles = 4'd2;
      LAT_DOT: latCycles = 4'd4;
      default: latCycles = 4'd7;
    endcase
  endfunction

endpackage

// File: rtl/sbSlotFile.sv
module sbSlotFile
  import hazardSbPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 6,
  parameter int NUM_SRC     = 3,
  parameter int COMP        = 4,
  parameter int TAG_W       = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  sbCtrl_t                   ctrl,
  input  logic [ADDR_W-1:0]         dstAddr,
  input  logic [COMP-1:0]           wrMask,
  input  logic [TAG_W-1:0]          latLoad,
  input  logic [NUM_SRC*ADDR_W-1:0] srcAddr,
  input  logic [NUM_SRC*COMP-1:0]   srcMask,
  output logic [NUM_ENTRIES-1:0]    hitVec,
  output logic [NUM_ENTRIES-1:0]    freeVec,
  output logic [NUM_ENTRIES*TAG_W-1:0] tagVec
);

  logic [TAG_W-1:0]  tagQ  [NUM_ENTRIES];
  logic [ADDR_W-1:0] addrQ [NUM_ENTRIES];
  logic [COMP-1:0]   maskQ [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    logic takeThis;
    logic sameDst;
    logic liveNow;

    assign takeThis = ctrl.alloc && (int'(ctrl.idx) == e);
    assign sameDst  = ctrl.alloc && (addrQ[e] == dstAddr);
    // a counter of 1 expires this cycle: the result is already readable
    assign liveNow  = (tagQ[e] > TAG_W'(1)) && (maskQ[e] != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        tagQ[e]  <= '0;
        addrQ[e] <= '0;
        maskQ[e] <= '0;
      end else if (takeThis) begin
        tagQ[e]  <= latLoad;
        addrQ[e] <= dstAddr;
        maskQ[e] <= wrMask;
      end else begin
        if (tagQ[e] != '0) tagQ[e] <= tagQ[e] - TAG_W'(1);
        if (sameDst) maskQ[e] <= maskQ[e] & ~wrMask;
      end
    end

    always_comb begin
      hitVec[e] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (liveNow && (srcAddr[s*ADDR_W +: ADDR_W] == addrQ[e]) &&
            ((srcMask[s*COMP +: COMP] & maskQ[e]) != '0))
          hitVec[e] = 1'b1;
      end
    end

    assign freeVec[e] = !liveNow;
    assign tagVec[e*TAG_W +: TAG_W] = tagQ[e];
  end

endmodule

// File: rtl/sbIssueCtrl.sv
module sbIssueCtrl
  import hazardSbPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int COMP        = 4
) (
  input  logic                   issueValid,
  input  logic [COMP-1:0]        wrMask,
  input  logic [NUM_ENTRIES-1:0] hitVec,
  input  logic [NUM_ENTRIES-1:0] freeVec,
  output logic                   stall,
  output sbCtrl_t                ctrl
);

  logic                anyFree;
  logic [SB_IDX_W-1:0] freeIdx;
  logic                needSlot;
  logic                hazard;

  // lowest-numbered free slot
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i]) begin
        anyFree = 1'b1;
        freeIdx = SB_IDX_W'(i);
      end
    end
  end

  assign needSlot   = (wrMask != '0);
  assign hazard     = |hitVec;
  assign stall      = issueValid && (hazard || (needSlot && !anyFree));
  assign ctrl.alloc = issueValid && !stall && needSlot;
  assign ctrl.idx   = freeIdx;

endmodule

// File: rtl/hazardScoreboard.sv
module hazardScoreboard
  import hazardSbPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 6,
  parameter int NUM_SRC     = 3,
  parameter int TAG_W       = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issueValid,
  input  logic [NUM_SRC*ADDR_W-1:0] srcAddr,
  input  logic [NUM_SRC*4-1:0]      srcMask,
  input  logic [ADDR_W-1:0]         dstAddr,
  input  logic [3:0]                wrMask,
  input  logic [1:0]                latClass,
  output logic                      stall
);

  localparam int COMP = 4;

  sbCtrl_t                      ctrl;
  logic [NUM_ENTRIES-1:0]       hitVec;
  logic [NUM_ENTRIES-1:0]       freeVec;
  logic [NUM_ENTRIES*TAG_W-1:0] tagVec;
  logic [TAG_W-1:0]             latLoad;

  assign latLoad = TAG_W'(latCycles(latClass));

  sbSlotFile #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
    .COMP(COMP), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dstAddr(dstAddr), .wrMask(wrMask),
    .latLoad(latLoad), .srcAddr(srcAddr), .srcMask(srcMask),
    .hitVec(hitVec), .freeVec(freeVec), .tagVec(tagVec)
  );

  sbIssueCtrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .COMP(COMP)
  ) u_ctrl (
    .issueValid(issueValid), .wrMask(wrMask), .hitVec(hitVec),
    .freeVec(freeVec), .stall(stall), .ctrl(ctrl)
  );

endmodule

// File: rtl/hazardScoreboardChk.sv
module hazardScoreboardChk
  import hazardSbPkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 6,
  parameter int NUM_SRC     = 3,
  parameter int TAG_W       = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         issueValid,
  input logic [NUM_SRC*ADDR_W-1:0]    srcAddr,
  input logic [NUM_SRC*4-1:0]         srcMask,
  input logic [ADDR_W-1:0]            dstAddr,
  input logic [3:0]                   wrMask,
  input logic [1:0]                   latClass,
  input logic                         stall,
  input sbCtrl_t                      ctrl,
  input logic [NUM_ENTRIES-1:0]       freeVec,
  input logic [NUM_ENTRIES*TAG_W-1:0] tagVec
);

  p_idle_no_stall_r10: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> !stall);

  p_bubble_no_claim_r5: assert property (@(posedge clk) disable iff (rst)
    stall |-> !ctrl.alloc);

  p_claim_free_slot_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl.alloc |-> freeVec[ctrl.idx]);

  // a special-function write blocks an overlapping read on the next cycle
  p_sfu_blocks_reader_r2: assert property (@(posedge clk) disable iff (rst)
    (issueValid && !stall && (wrMask != 4'd0) && (latClass == 2'd3)) |=>
      (!(issueValid && (srcAddr[ADDR_W-1:0] == $past(dstAddr)) &&
         ((srcMask[3:0] & $past(wrMask)) != 4'd0)) || stall));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_tag
    p_tag_step_r9: assert property (@(posedge clk) disable iff (rst)
      ((tagVec[e*TAG_W +: TAG_W] != '0) &&
       !(ctrl.alloc && (int'(ctrl.idx) == e))) |=>
        (tagVec[e*TAG_W +: TAG_W] == $past(tagVec[e*TAG_W +: TAG_W]) - TAG_W'(1)));

    p_tag_range_r4: assert property (@(posedge clk) disable iff (rst)
      ctrl.alloc |=> (tagVec[e*TAG_W +: TAG_W] <= TAG_W'(7)));
  end

endmodule

bind hazardScoreboard hazardScoreboardChk #(
  .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W)
) chk (
  .clk(clk), .rst(rst), .issueValid(issueValid), .srcAddr(srcAddr),
  .srcMask(srcMask), .dstAddr(dstAddr), .wrMask(wrMask), .latClass(latClass),
  .stall(stall), .ctrl(ctrl), .freeVec(freeVec), .tagVec(tagVec)
);

// File: tb/hazardScoreboard_test.sv
`timescale 1ns/1ps
module hazardScoreboard_test;

  localparam int AW = 6;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issueValid = 1'b0;
  logic [NS*AW-1:0] srcAddr = '0;
  logic [NS*4-1:0]  srcMask = '0;
  logic [AW-1:0]    dstAddr = '0;
  logic [3:0]       wrMask = '0;
  logic [1:0]       latClass = '0;
  logic          stall, stall2;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  string tagNow = "R1";

  typedef struct {int addr; int mask; int ready;} rec_t;
  rec_t q1[$];
  rec_t q2[$];

  always #2.5 clk = ~clk;

  hazardScoreboard #(.NUM_ENTRIES(8), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .srcAddr(srcAddr),
    .srcMask(srcMask), .dstAddr(dstAddr), .wrMask(wrMask),
    .latClass(latClass), .stall(stall));

  hazardScoreboard #(.NUM_ENTRIES(4), .ADDR_W(AW)) uut2 (
    .clk(clk), .rst(rst), .issueValid(issueValid), .srcAddr(srcAddr),
    .srcMask(srcMask), .dstAddr(dstAddr), .wrMask(wrMask),
    .latClass(latClass), .stall(stall2));

  function automatic int latOf(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic bit predict(ref rec_t q[$], input int slots, input int now);
    int liveCnt = 0;
    bit haz = 0;
    foreach (q[i]) begin
      if (q[i].ready > now && q[i].mask != 0) begin
        liveCnt++;
        for (int s = 0; s < NS; s++)
          if (int'(srcAddr[s*AW +: AW]) == q[i].addr &&
              (int'(srcMask[s*4 +: 4]) & q[i].mask) != 0) haz = 1;
      end
    end
    return issueValid && (haz || (wrMask != 0 && liveCnt >= slots));
  endfunction

  task automatic commit(ref rec_t q[$], input bit st, input int now);
    if (issueValid && !st && wrMask != 0) begin
      foreach (q[i]) if (q[i].addr == int'(dstAddr)) q[i].mask &= ~int'(wrMask);
      q.push_back('{int'(dstAddr), int'(wrMask), now + latOf(int'(latClass))});
    end
    for (int i = q.size() - 1; i >= 0; i--)
      if (q[i].ready <= now + 1) q.delete(i);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // one clock: compare both instances, advance models; returns the stall of the chosen instance
  task automatic step(input int which, output bit st);
    bit e1, e2;
    #1;
    e1 = predict(q1, 8, cyc);
    e2 = predict(q2, 4, cyc);
    check(tagNow, int'(stall), int'(e1));
    check(tagNow, int'(stall2), int'(e2));
    st = (which == 0) ? e1 : e2;
    @(posedge clk);
    commit(q1, e1, cyc);
    commit(q2, e2, cyc);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bit st;
    issueValid = 0;
    for (int i = 0; i < n; i++) step(0, st);
  endtask

  task automatic setSrc(input int k, input int a, input int m);
    srcAddr[k*AW +: AW] = AW'(a);
    srcMask[k*4 +: 4]   = 4'(m);
  endtask

  // present an instruction until the chosen instance accepts it
  task automatic issue(input int which, input int dst, input int wm, input int cls,
                       output int stalls);
    bit st;
    issueValid = 1;
    dstAddr = AW'(dst);
    wrMask = 4'(wm);
    latClass = 2'(cls);
    stalls = 0;
    do begin
      step(which, st);
      if (st) stalls++;
    end while (st && stalls < 50);
    issueValid = 0;
    srcMask = '0;
    wrMask = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit st;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reads after reset see nothing live
    tagNow = "R1";
    setSrc(0, 10, 15); setSrc(1, 0, 15); setSrc(2, 63, 15);
    issue(0, 0, 0, 0, n);
    check("R1 reset stall count", n, 0);

    // R4 and R2: stall length equals latency minus one for every class
    tagNow = "R4";
    for (int c = 0; c < 4; c++) begin
      issue(0, 10, 15, c, n);
      setSrc(0, 10, 1);
      issue(0, 11, 1, 0, n);
      check("R4 dependent stall count", n, latOf(c) - 1);
      idle(8);
    end

    // R8: the third and second source slots are checked too
    tagNow = "R8";
    issue(0, 20, 4, 3, n);
    setSrc(0, 1, 15); setSrc(1, 2, 15); setSrc(2, 20, 4);
    issue(0, 0, 0, 0, n);
    check("R8 slot2 stall count", n, 6);
    idle(8);
    issue(0, 20, 4, 3, n);
    setSrc(1, 20, 4); setSrc(2, 20, 0);
    issue(0, 0, 0, 0, n);
    check("R8 slot1 stall count", n, 6);
    setSrc(1, 20, 0);
    idle(8);

    // R3: disjoint lanes pass
    tagNow = "R3";
    issue(0, 21, 1, 3, n);
    setSrc(0, 21, 14);
    issue(0, 0, 0, 0, n);
    check("R3 disjoint lane stall count", n, 0);
    idle(8);

    // R6: a younger write to the same lanes takes over
    tagNow = "R6";
    issue(0, 5, 15, 3, n);
    issue(0, 5, 15, 0, n);
    setSrc(0, 5, 15);
    issue(0, 0, 0, 0, n);
    check("R6 superseded full stall count", n, 0);
    idle(8);
    issue(0, 6, 15, 3, n);
    issue(0, 6, 1, 0, n);
    setSrc(0, 6, 2);
    issue(0, 0, 0, 0, n);
    check("R6 uncovered lane stall count", n, 5);
    idle(8);

    // R5: a write presented without issueValid claims nothing
    tagNow = "R5";
    dstAddr = AW'(7); wrMask = 4'hF; latClass = 2'd3;
    step(0, st);
    wrMask = '0;
    setSrc(0, 7, 15);
    issue(0, 0, 0, 0, n);
    check("R5 invalid write stall count", n, 0);
    idle(8);

    // R10: a live hazard does not stall an idle slot
    tagNow = "R10";
    issue(0, 40, 15, 3, n);
    setSrc(0, 40, 15);
    step(0, st);
    check("R10 idle stall", int'(st), 0);
    issue(0, 0, 0, 0, n);
    check("R10 late reader stall count", n, 5);
    idle(8);

    // R7: the four-slot instance fills up
    tagNow = "R7";
    for (int i = 0; i < 4; i++) begin
      issue(1, 30 + i, 15, 3, n);
      check("R7 fill stall count", n, 0);
    end
    issue(1, 0, 0, 0, n);
    check("R7 no-write while full stall count", n, 0);
    issue(1, 35, 15, 3, n);
    check("R7 full stall count", n, 2);
    idle(8);
    for (int i = 0; i < 5; i++) issue(1, 50 + i, 15, 3, n);
    check("R7 fifth writer stall count", n, 3);
    idle(8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule